// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects thirty-two level-sensitive request lines and drives two request outputs toward a processor core: a normal request and a fast request. For each of the two kinds it keeps its own enable mask. The raw lines appear in a signal view, and a status view shows each line ANDed with its enable. Software can raise or drop one programmed source of either kind through a configuration register. The enable masks have no effect on programmed sources.

Software can switch on vectoring for each kind on its own. With vectoring on, every source carries a 3-bit priority, where 0 is the most urgent. The block picks the winning source and presents a vector word built from a 16-bit base and the winner's index. The handler claims the winner, which pushes its priority onto a per-kind nesting stack up to eight deep. After a claim, only a strictly more urgent source raises that request again. An end-of-service write pops the stack. While a fast request is in service, the normal request is held low.

Access is through a plain single-cycle register port. Writes take effect at the clock edge and reads are combinational from the address. The block has no streaming data path, so every pin is a plain control or status signal with no valid/ready back-pressure.

Top module: `vpic_top`

## Requirements
- R1: Word offsets: 0 normal signal (RO), 1 normal enable, 2 normal status (RO), 3 fast signal (RO), 4 fast enable, 5 fast status (RO). For each kind, the signal view equals the source lines with the programmed bit ORed into bit 1. For hardware lines, the status view equals signal AND enable.
- R2: With vectoring off for a kind, that kind's request output is 1 exactly when any of its status bits is 1.
- R3: Writing offset 6 loads the programmed sources. Data bit 1 sets or clears bit 1 of the normal signal and status views, and data bit 2 does the same for the fast views. Programmed bits reach status even when the enable bit is 0.
- R4: Bits 0 and 31:3 of offset 6 are ignored: they change no view, and offset 6 reads back only bits 2:1.
- R5: Offset 7 bit 0 turns on normal vectoring and bit 1 turns on fast vectoring. Claim writes to a kind whose vectoring is off are ignored.
- R6: Offsets 9, 10 and 11 form a 96-bit priority vector {off11, off10, off9}, in which source i uses bits 3i+2:3i. The winner is the active source with the lowest number, and a tie goes to the lowest index.
- R7: Offset 12 reads the vector word. Bits 6:2 hold the winner's index and bits 22:7 hold the base. Bit 23 is 1 when the word refers to a fast source. All other bits are 0. The fast winner is shown when fast vectoring is on and a fast request qualifies; otherwise the normal winner is shown.
- R8: Writing offset 13 with bit 0 (normal) or bit 1 (fast) claims that kind's winner, but only while its request output is 1. A claim pushes the winner's priority. While the stack is not empty, a source qualifies only if its number is below the top entry. Writing offset 14 with bit 0 or bit 1 pops that stack, and a pop of an empty stack is ignored. Depth stays between 0 and 8. Offset 15 reads the normal depth in bits 3:0 and the fast depth in bits 7:4.
- R9: While the fast stack is not empty, the normal request output is 0.
- R10: Offset 8 stores a 16-bit vector base in bits 15:0, and bits 31:16 read as 0.
- R11: After reset, every register and view reads 0, both requests are 0 and the vector word is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_i | input | 32 | Level-sensitive request lines |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register word offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr |
| req_norm_o | output | 1 | Normal request to the core |
| req_fast_o | output | 1 | Fast request to the core |
| vec_o | output | 32 | Current vector word |

## Verification
The assertions check on every cycle that the stack depth never passes eight and that depth moves by one on each accepted push or pop. They also check that a claimed entry holds the winner's priority and that the winner is raised, qualifies, and is not beaten by any other candidate. Finally, they check that fast service silences the normal request and that the fast flag in the vector comes only with a fast request. The bench scenarios are the only place that shows the actual AND-with-enable values and the set and clear of programmed sources. The same holds for the priority field positions, the exact vector word, and claims or pops being ignored at the limits.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam logic [3:0] A_NSIG  = 4'd0;
  localparam logic [3:0] A_NEN   = 4'd1;
  localparam logic [3:0] A_NSTAT = 4'd2;
  localparam logic [3:0] A_FSIG  = 4'd3;
  localparam logic [3:0] A_FEN   = 4'd4;
  localparam logic [3:0] A_FSTAT = 4'd5;
  localparam logic [3:0] A_SWI   = 4'd6;
  localparam logic [3:0] A_CONN  = 4'd7;
  localparam logic [3:0] A_BASE  = 4'd8;
  localparam logic [3:0] A_PRI0  = 4'd9;
  localparam logic [3:0] A_VEC   = 4'd12;
  localparam logic [3:0] A_CLAIM = 4'd13;
  localparam logic [3:0] A_EOS   = 4'd14;
  localparam logic [3:0] A_DEPTH = 4'd15;

  localparam int PROG_IDX  = 1;
  localparam int SWI_N_BIT = 1;
  localparam int SWI_F_BIT = 2;
  localparam int IDX_LSB   = 2;
endpackage

// File: rtl/vpic_arb.sv
module vpic_arb #(
  parameter int NSRC = 32,
  parameter int PW   = 3,
  localparam int IW  = $clog2(NSRC)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req,
  input  logic [NSRC*PW-1:0] pri_flat,
  input  logic              lim_en,
  input  logic [PW-1:0]     lim,
  output logic              hit,
  output logic [IW-1:0]     idx,
  output logic [PW-1:0]     win_pri
);
  // linear scan: strict compare keeps the lower index on ties
  always_comb begin
    logic [PW-1:0] p;
    hit     = 1'b0;
    idx     = '0;
    win_pri = '0;
    for (int i = 0; i < NSRC; i++) begin
      p = pri_flat[i*PW +: PW];
      if (req[i] && (!lim_en || p < lim) && (!hit || p < win_pri)) begin
        hit     = 1'b1;
        idx     = IW'(i);
        win_pri = p;
      end
    end
  end

  // independent search for a candidate that should have won instead
  logic better;
  always_comb begin
    logic [PW-1:0] q;
    better = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      q = pri_flat[i*PW +: PW];
      if (req[i] && (!lim_en || q < lim) &&
          (!hit || q < win_pri || (q == win_pri && IW'(i) < idx)))
        better = 1'b1;
    end
  end

  a_r6_winner_raised: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> req[idx]);
  a_r6_none_better: assert property (@(posedge clk) disable iff (!rst_n)
    !better);
  a_r8_strictly_higher: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && lim_en) |-> (win_pri < lim));
endmodule

// File: rtl/vpic_nest.sv
module vpic_nest #(
  parameter int DEPTH = 8,
  parameter int PW    = 3,
  localparam int DW   = $clog2(DEPTH + 1),
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic          pop,
  input  logic [PW-1:0] push_val,
  output logic [DW-1:0] depth,
  output logic [PW-1:0] top
);
  logic [PW-1:0] stk [DEPTH];
  logic [DW-1:0] dm1;
  logic          can_push;

  assign can_push = depth < DW'(DEPTH);
  assign dm1      = depth - DW'(1);
  assign top      = (depth == '0) ? '0 : stk[dm1[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth <= '0;
    end else if (push && can_push) begin
      depth <= depth + DW'(1);
    end else if (!push && pop && depth != '0) begin
      depth <= dm1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && can_push) stk[depth[AW-1:0]] <= push_val;
  end

  a_r8_depth_cap: assert property (@(posedge clk) disable iff (!rst_n)
    depth <= DW'(DEPTH));
  a_r8_push_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (push && depth < DW'(DEPTH)) |=> depth == $past(depth) + DW'(1));
  a_r8_pop_shrinks: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && pop && depth != '0) |=> depth == $past(depth) - DW'(1));
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int NSRC   = 32,
  parameter int PW     = 3,
  parameter int NEST   = 8,
  parameter int BASE_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] src_i,
  input  logic        wr_en,
  input  logic [3:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        req_norm_o,
  output logic        req_fast_o,
  output logic [31:0] vec_o
);
  localparam int IW       = $clog2(NSRC);
  localparam int DW       = $clog2(NEST + 1);
  localparam int NPRI     = (NSRC * PW + 31) / 32;
  localparam int BASE_LSB = IDX_LSB + IW;
  localparam int FLAG_BIT = BASE_LSB + BASE_W;

  // ---------------- configuration registers ----------------
  logic [NSRC-1:0]   n_en, f_en;
  logic              swi_n, swi_f;
  logic [1:0]        conn;
  logic [BASE_W-1:0] base;
  logic [31:0]       pri_q [NPRI];
  logic [NPRI*32-1:0] pri_all;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_en  <= '0;
      f_en  <= '0;
      swi_n <= 1'b0;
      swi_f <= 1'b0;
      conn  <= '0;
      base  <= '0;
    end else if (wr_en) begin
      case (addr)
        A_NEN:  n_en <= wdata[NSRC-1:0];
        A_FEN:  f_en <= wdata[NSRC-1:0];
        A_SWI: begin
          swi_n <= wdata[SWI_N_BIT];
          swi_f <= wdata[SWI_F_BIT];
        end
        A_CONN: conn <= wdata[1:0];
        A_BASE: base <= wdata[BASE_W-1:0];
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < NPRI; k++) begin : g_pri
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pri_q[k] <= '0;
      else if (wr_en && addr == A_PRI0 + 4'(k)) pri_q[k] <= wdata;
    end
    assign pri_all[k*32 +: 32] = pri_q[k];
  end

  // ---------------- signal and status views ----------------
  logic [NSRC-1:0] n_prog, f_prog, n_sig, f_sig, n_stat, f_stat;

  always_comb begin
    n_prog = '0;
    f_prog = '0;
    n_prog[PROG_IDX] = swi_n;
    f_prog[PROG_IDX] = swi_f;
  end

  assign n_sig  = src_i[NSRC-1:0] | n_prog;
  assign f_sig  = src_i[NSRC-1:0] | f_prog;
  assign n_stat = (src_i[NSRC-1:0] & n_en) | n_prog;
  assign f_stat = (src_i[NSRC-1:0] & f_en) | f_prog;

  // ---------------- arbitration and nesting ----------------
  logic          n_vec, f_vec;
  logic [DW-1:0] n_depth, f_depth;
  logic [PW-1:0] n_top, f_top, n_wpri, f_wpri;
  logic [IW-1:0] n_idx, f_idx;
  logic          n_hit, f_hit;
  logic          n_push, f_push, n_pop, f_pop;

  assign n_vec = conn[0];
  assign f_vec = conn[1];

  vpic_arb #(.NSRC(NSRC), .PW(PW)) u_arb_n (
    .clk, .rst_n, .req(n_stat), .pri_flat(pri_all[NSRC*PW-1:0]),
    .lim_en(n_vec && n_depth != '0), .lim(n_top),
    .hit(n_hit), .idx(n_idx), .win_pri(n_wpri));

  vpic_arb #(.NSRC(NSRC), .PW(PW)) u_arb_f (
    .clk, .rst_n, .req(f_stat), .pri_flat(pri_all[NSRC*PW-1:0]),
    .lim_en(f_vec && f_depth != '0), .lim(f_top),
    .hit(f_hit), .idx(f_idx), .win_pri(f_wpri));

  assign req_fast_o = f_vec ? f_hit : (|f_stat);
  assign req_norm_o = (f_depth == '0) && (n_vec ? n_hit : (|n_stat));

  assign n_push = wr_en && addr == A_CLAIM && wdata[0] && n_vec && req_norm_o;
  assign f_push = wr_en && addr == A_CLAIM && wdata[1] && f_vec && req_fast_o;
  assign n_pop  = wr_en && addr == A_EOS && wdata[0];
  assign f_pop  = wr_en && addr == A_EOS && wdata[1];

  vpic_nest #(.DEPTH(NEST), .PW(PW)) u_nest_n (
    .clk, .rst_n, .push(n_push), .pop(n_pop), .push_val(n_wpri),
    .depth(n_depth), .top(n_top));

  vpic_nest #(.DEPTH(NEST), .PW(PW)) u_nest_f (
    .clk, .rst_n, .push(f_push), .pop(f_pop), .push_val(f_wpri),
    .depth(f_depth), .top(f_top));

  // ---------------- vector word ----------------
  logic use_f;
  assign use_f = f_vec && f_hit;

  always_comb begin
    vec_o = '0;
    vec_o[IDX_LSB +: IW]     = use_f ? f_idx : n_idx;
    vec_o[BASE_LSB +: BASE_W] = base;
    vec_o[FLAG_BIT]          = use_f;
  end

  // ---------------- read mux ----------------
  always_comb begin
    rdata = '0;
    case (addr)
      A_NSIG:  rdata = 32'(n_sig);
      A_NEN:   rdata = 32'(n_en);
      A_NSTAT: rdata = 32'(n_stat);
      A_FSIG:  rdata = 32'(f_sig);
      A_FEN:   rdata = 32'(f_en);
      A_FSTAT: rdata = 32'(f_stat);
      A_SWI:   rdata = (32'(swi_f) << SWI_F_BIT) | (32'(swi_n) << SWI_N_BIT);
      A_CONN:  rdata = 32'(conn);
      A_BASE:  rdata = 32'(base);
      A_VEC:   rdata = vec_o;
      A_DEPTH: rdata = 32'({f_depth, n_depth});
      default: begin
        for (int k = 0; k < NPRI; k++)
          if (addr == A_PRI0 + 4'(k)) rdata = pri_q[k];
      end
    endcase
  end

  a_r9_fast_holds_normal: assert property (@(posedge clk) disable iff (!rst_n)
    (f_depth != '0) |-> !req_norm_o);
  a_r7_flag_means_fast: assert property (@(posedge clk) disable iff (!rst_n)
    vec_o[FLAG_BIT] |-> req_fast_o);
  a_r8_claim_records: assert property (@(posedge clk) disable iff (!rst_n)
    n_push |=> n_top == $past(n_wpri));
  a_r8_fast_claim_records: assert property (@(posedge clk) disable iff (!rst_n)
    f_push |=> f_top == $past(f_wpri));
endmodule

// File: tb/vpic_top_tb.sv
module vpic_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_i = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, vec_o;
  logic        req_norm_o, req_fast_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vpic_top u_dut (
    .clk, .rst_n, .src_i, .wr_en, .addr, .wdata,
    .rdata, .req_norm_o, .req_fast_o, .vec_o);

  typedef struct packed {
    logic [31:0] src;
    logic [31:0] nen;
    logic [31:0] fen;
    logic [2:0]  swi;
    logic [31:0] xn;
    logic [31:0] xf;
  } row_t;

  localparam row_t TBL [6] = '{
    '{32'h0000_00F0, 32'h0000_0030, 32'h0000_00C0, 3'd0, 32'h0000_0030, 32'h0000_00C0},
    '{32'hFFFF_FFFF, 32'h8000_0001, 32'h0000_0000, 3'd0, 32'h8000_0001, 32'h0000_0000},
    '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 3'd2, 32'h0000_0002, 32'h0000_0000},
    '{32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 3'd4, 32'h0000_0000, 32'h0000_0002},
    '{32'h0000_0002, 32'h0000_0000, 32'h0000_0000, 3'd6, 32'h0000_0002, 32'h0000_0002},
    '{32'h1234_5678, 32'hFFFF_0000, 32'h0000_FFFF, 3'd1, 32'h1234_0000, 32'h0000_5678}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic set_src(input logic [31:0] s);
    @(negedge clk);
    src_i = s;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    for (int a = 0; a < 16; a++) begin
      rd(4'(a), d);
      chk($sformatf("R11 reg %0d after reset", a), d, 32'h0);
    end
    chk("R11 req_norm after reset", 32'(req_norm_o), 32'h0);
    chk("R11 req_fast after reset", 32'(req_fast_o), 32'h0);
    chk("R11 vec after reset", vec_o, 32'h0);

    // table walk: R1 R2 R3 R4 (vectoring off)
    for (int i = 0; i < 6; i++) begin
      set_src(TBL[i].src);
      wr(4'd1, TBL[i].nen);
      wr(4'd4, TBL[i].fen);
      wr(4'd6, 32'(TBL[i].swi));
      rd(4'd2, d); chk($sformatf("R1/R3 row %0d normal status", i), d, TBL[i].xn);
      rd(4'd5, d); chk($sformatf("R1/R3 row %0d fast status", i), d, TBL[i].xf);
      rd(4'd0, d); chk($sformatf("R1 row %0d normal signal", i), d,
                       TBL[i].src | (32'(TBL[i].swi[1]) << 1));
      rd(4'd3, d); chk($sformatf("R1 row %0d fast signal", i), d,
                       TBL[i].src | (32'(TBL[i].swi[2]) << 1));
      rd(4'd6, d); chk($sformatf("R4 row %0d swi readback", i), d,
                       32'(TBL[i].swi & 3'b110));
      chk($sformatf("R2 row %0d normal request", i), 32'(req_norm_o), 32'(TBL[i].xn != 0));
      chk($sformatf("R2 row %0d fast request", i), 32'(req_fast_o), 32'(TBL[i].xf != 0));
    end

    // R10: base register width
    wr(4'd6, 32'h0); wr(4'd4, 32'h0); wr(4'd1, 32'hFFFF_FFFF);
    wr(4'd8, 32'hFFFF_1234);
    rd(4'd8, d); chk("R10 base upper bits zero", d, 32'h0000_1234);
    wr(4'd8, 32'h0000_ABCD);

    // R5: claim ignored while vectoring is off
    set_src(32'h0000_0228);
    wr(4'd13, 32'h1);
    rd(4'd15, d); chk("R5 claim ignored when not vectored", d, 32'h0);

    // R5 R6 R7: vectoring on, all priorities equal -> lowest index 3
    wr(4'd7, 32'h1);
    rd(4'd7, d); chk("R5 connect readback", d, 32'h1);
    chk("R6 tie lowest index vector", vec_o, 32'h0055_E68C);
    chk("R5 normal request vectored", 32'(req_norm_o), 32'h1);

    // R6: src3=5, src5=2, src9=2 -> source 5
    wr(4'd9, 32'h1001_0A00);
    rd(4'd9, d); chk("R6 priority readback", d, 32'h1001_0A00);
    rd(4'd12, d); chk("R7 vector word source 5", d, 32'h0055_E694);

    // R8: nesting
    wr(4'd13, 32'h1);
    rd(4'd15, d); chk("R8 depth after claim", d, 32'h1);
    chk("R8 no strictly higher request", 32'(req_norm_o), 32'h0);
    set_src(32'h0000_1228);
    #1 chk("R8 higher source preempts", 32'(req_norm_o), 32'h1);
    chk("R7 vector word source 12", vec_o, 32'h0055_E6B0);
    wr(4'd13, 32'h1);
    rd(4'd15, d); chk("R8 depth two", d, 32'h2);
    wr(4'd13, 32'h1);
    rd(4'd15, d); chk("R8 claim without request ignored", d, 32'h2);
    wr(4'd14, 32'h1);
    rd(4'd15, d); chk("R8 pop to one", d, 32'h1);
    chk("R8 request returns after pop", 32'(req_norm_o), 32'h1);
    wr(4'd14, 32'h1);
    wr(4'd14, 32'h1);
    rd(4'd15, d); chk("R8 pop of empty ignored", d, 32'h0);

    // R8: eight levels
    set_src(32'h0);
    wr(4'd9, 32'h0005_3977);
    for (int i = 0; i < 8; i++) begin
      set_src((32'h2 << i) - 32'h1);
      wr(4'd13, 32'h1);
    end
    rd(4'd15, d); chk("R8 depth eight", d, 32'h8);
    wr(4'd13, 32'h1);
    rd(4'd15, d); chk("R8 depth stays at eight", d, 32'h8);
    chk("R8 no request at full depth", 32'(req_norm_o), 32'h0);
    for (int i = 0; i < 8; i++) wr(4'd14, 32'h1);
    rd(4'd15, d); chk("R8 unwound to zero", d, 32'h0);

    // R9: fast over normal
    set_src(32'h0010_1000);
    wr(4'd1, 32'h0000_1000);
    wr(4'd4, 32'h0010_0000);
    wr(4'd7, 32'h3);
    chk("R9 fast request", 32'(req_fast_o), 32'h1);
    chk("R9 normal request before fast claim", 32'(req_norm_o), 32'h1);
    chk("R7 fast vector word", vec_o, 32'h00D5_E6D0);
    wr(4'd13, 32'h2);
    rd(4'd15, d); chk("R9 fast depth", d, 32'h10);
    chk("R9 normal held during fast service", 32'(req_norm_o), 32'h0);
    chk("R7 vector falls back to normal", vec_o, 32'h0055_E6B0);
    wr(4'd14, 32'h2);
    rd(4'd15, d); chk("R9 fast popped", d, 32'h0);
    chk("R9 normal released", 32'(req_norm_o), 32'h1);

    // R11: reset again
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    set_src(32'h0);
    rd(4'd7, d); chk("R11 connect cleared by reset", d, 32'h0);
    rd(4'd8, d); chk("R11 base cleared by reset", d, 32'h0);
    rd(4'd9, d); chk("R11 priority cleared by reset", d, 32'h0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule